// File: doc/BRIEF.md
# Tuner Control Register Slave on I2C

This block is a receive-mostly I2C target that loads the frequency divider word and the control/band word of a tuner synthesizer. A bus master addresses it, then sends up to two byte pairs. The block works out the type of each pair from the first byte of that pair, so a divider pair and a control pair may come in either order, and either may come without the other. Nothing reaches the parallel outputs until the master ends the transfer with a stop condition. Only pairs that arrived complete are copied out, and each copied word is announced with a one-cycle strobe.

A read transfer returns the 8-bit status input, MSB first, for as long as the master keeps acknowledging. The two address-select pins choose one of four device addresses, so up to four of these blocks can share one bus. The system clock must run at least 16 times faster than SCL. The data line is open-drain: the block only ever asks for SDA to be pulled low.

Top module: `tuner_i2c_slave`

## Requirements
- R1: While reset is asserted, and after its release, both output words are zero, both strobes are low, and the SDA pull-down is off.
- R2: The device address is bits 6:2 of BASE_ADDR followed by addr_sel_i[1:0]. Bit 0 of the address byte is the direction: 0 means write and 1 means read. On a matching address byte the block pulls SDA low during the ninth (acknowledge) clock.
- R3: On an address byte that does not match, the block gives no acknowledge. It then stays off the bus until the next start, so the following bytes get no acknowledge and the stop that ends the transfer changes no output.
- R4: In a write transfer, every data byte is acknowledged with SDA held low during its ninth clock.
- R5: Bit 7 of the first byte of a pair sets the pair type: 0 marks a divider pair and 1 marks a control pair. The second byte is taken as it is. The resulting word is {first byte, second byte}.
- R6: In a divider-then-control transfer and in a control-then-divider transfer, the stop loads both words. Each word has its own strobe, high for exactly one cycle, and asserted while the synchronized SCL and SDA are both high.
- R7: A transfer that carries only one pair loads only that word and pulses only its strobe. The other word keeps its value, and neither word changes without its strobe.
- R8: A pair that is missing its second byte when the stop arrives is dropped. Complete pairs sent earlier in the same transfer are still loaded.
- R9: A repeated start drops every byte received since the previous start. Address reception begins again, and only pairs sent after the repeated start are loaded at the stop.
- R10: In a read transfer, status_i is shifted out MSB first. After a master acknowledge the status byte is sent again. After a master non-acknowledge the pull-down is released and stays off until the next start.
- R11: The SDA pull-down only changes while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as received |
| sda_i | input | 1 | Bus data as received (the wired-AND level) |
| addr_sel_i | input | 2 | Replaces the two lowest address bits |
| status_i | input | 8 | Byte returned on read transfers |
| sda_drive_low_o | output | 1 | When high, SDA is pulled low |
| div_word_o | output | 16 | Last divider word loaded |
| ctl_word_o | output | 16 | Last control/band word loaded |
| div_upd_o | output | 1 | One-cycle pulse when div_word_o is loaded |
| ctl_upd_o | output | 1 | One-cycle pulse when ctl_word_o is loaded |

## Verification
The bench builds the block with BASE_ADDR = 7'h63. Its two low bits are set, so they differ from the select pins the bench drives. Any design that compares the full base value instead of replacing those two bits would then fail to acknowledge at select values 0 and 2. Driving the select pins with 0 and then 2 reaches two of the four addresses. Addressing 7'h61 while the pins are at 2 shows that a neighbouring address is refused.

// File: rtl/tuner_i2c_slave.sv
module tuner_i2c_slave #(
  parameter logic [6:0] BASE_ADDR = 7'h60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [1:0]  addr_sel_i,
  input  logic [7:0]  status_i,
  output logic        sda_drive_low_o,
  output logic [15:0] div_word_o,
  output logic [15:0] ctl_word_o,
  output logic        div_upd_o,
  output logic        ctl_upd_o
);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_ADDR = 3'd1, S_AACK = 3'd2, S_WR = 3'd3,
    S_WACK = 3'd4, S_RD = 3'd5, S_RACK = 3'd6, S_IGN = 3'd7
  } st_t;

  st_t         st;
  logic [2:0]  scl_q, sda_q;
  logic [3:0]  cnt;
  logic [7:0]  sh, tx, hold;
  logic [15:0] div_sh, ctl_sh;
  logic        div_ok, ctl_ok, pos, cur_ctl, rw, mnack;

  wire scl_s = scl_q[1];
  wire scl_d = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_d = sda_q[2];

  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire byte_end = scl_fall & (cnt == 4'd8);

  wire [6:0] my_addr = {BASE_ADDR[6:2], addr_sel_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st              <= S_IDLE;
      cnt             <= '0;
      sh              <= '0;
      tx              <= '0;
      hold            <= '0;
      div_sh          <= '0;
      ctl_sh          <= '0;
      div_ok          <= 1'b0;
      ctl_ok          <= 1'b0;
      pos             <= 1'b0;
      cur_ctl         <= 1'b0;
      rw              <= 1'b0;
      mnack           <= 1'b0;
      sda_drive_low_o <= 1'b0;
      div_word_o      <= '0;
      ctl_word_o      <= '0;
      div_upd_o       <= 1'b0;
      ctl_upd_o       <= 1'b0;
    end else begin
      div_upd_o <= 1'b0;
      ctl_upd_o <= 1'b0;
      if (start_c) begin
        st              <= S_ADDR;
        cnt             <= '0;
        pos             <= 1'b0;
        div_ok          <= 1'b0;
        ctl_ok          <= 1'b0;
        sda_drive_low_o <= 1'b0;
      end else if (stop_c) begin
        st              <= S_IDLE;
        pos             <= 1'b0;
        div_ok          <= 1'b0;
        ctl_ok          <= 1'b0;
        sda_drive_low_o <= 1'b0;
        if (div_ok) begin
          div_word_o <= div_sh;
          div_upd_o  <= 1'b1;
        end
        if (ctl_ok) begin
          ctl_word_o <= ctl_sh;
          ctl_upd_o  <= 1'b1;
        end
      end else begin
        case (st)
          S_ADDR, S_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (sh[7:1] == my_addr) begin
                  st              <= S_AACK;
                  rw              <= sh[0];
                  sda_drive_low_o <= 1'b1;
                end else begin
                  st <= S_IGN;
                end
              end else begin
                st              <= S_WACK;
                sda_drive_low_o <= 1'b1;
                if (!pos) begin
                  hold    <= sh;
                  cur_ctl <= sh[7];
                  pos     <= 1'b1;
                end else begin
                  pos <= 1'b0;
                  if (cur_ctl) begin
                    ctl_sh <= {hold, sh};
                    ctl_ok <= 1'b1;
                  end else begin
                    div_sh <= {hold, sh};
                    div_ok <= 1'b1;
                  end
                end
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              if (rw) begin
                st              <= S_RD;
                tx              <= status_i;
                sda_drive_low_o <= ~status_i[7];
              end else begin
                st              <= S_WR;
                sda_drive_low_o <= 1'b0;
              end
            end
          end
          S_WACK: begin
            if (scl_fall) begin
              st              <= S_WR;
              sda_drive_low_o <= 1'b0;
            end
          end
          S_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 4'd1;
            end else if (byte_end) begin
              cnt             <= '0;
              st              <= S_RACK;
              sda_drive_low_o <= 1'b0;
            end else if (scl_fall) begin
              tx              <= {tx[6:0], 1'b0};
              sda_drive_low_o <= ~tx[6];
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mnack <= sda_s;
            end else if (scl_fall) begin
              if (mnack) begin
                st <= S_IGN;
              end else begin
                st              <= S_RD;
                tx              <= status_i;
                sda_drive_low_o <= ~status_i[7];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/tuner_i2c_slave_chk.sv
module tuner_i2c_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        sda_s,
  input logic [2:0]  st,
  input logic        drive,
  input logic [15:0] div_word,
  input logic [15:0] ctl_word,
  input logic        div_upd,
  input logic        ctl_upd
);

  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drive) |-> !scl_s);

  assert_div_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_upd |=> !div_upd);

  assert_ctl_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_upd |=> !ctl_upd);

  assert_strobe_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_upd || ctl_upd) |-> (scl_s && sda_s));

  assert_div_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (div_word != $past(div_word)) |-> div_upd);

  assert_ctl_needs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_word != $past(ctl_word)) |-> ctl_upd);

  assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd7) |-> !drive);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !drive);

endmodule

bind tuner_i2c_slave tuner_i2c_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_q[1]),
  .sda_s    (sda_q[1]),
  .st       (st),
  .drive    (sda_drive_low_o),
  .div_word (div_word_o),
  .ctl_word (ctl_word_o),
  .div_upd  (div_upd_o),
  .ctl_upd  (ctl_upd_o)
);

// File: tb/test_tuner_i2c_slave.sv
module test_tuner_i2c_slave;
  localparam logic [6:0] BASE = 7'h63;
  localparam time Q = 80ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  addr_sel = 2'd0;
  logic [7:0]  status = 8'h00;
  logic        drv, div_upd, ctl_upd;
  logic [15:0] div_w, ctl_w;
  wire         sda_bus = sda_m & ~drv;

  int n_chk = 0;
  int n_fail = 0;
  int r11_viol = 0;
  bit done = 1'b0;
  logic [16:0] exp_q[$];
  logic [15:0] m_div = '0;
  logic [15:0] m_ctl = '0;

  always #4ns clk = ~clk;

  tuner_i2c_slave #(.BASE_ADDR(BASE)) i_tuner_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .addr_sel_i(addr_sel), .status_i(status),
    .sda_drive_low_o(drv), .div_word_o(div_w), .ctl_word_o(ctl_w),
    .div_upd_o(div_upd), .ctl_upd_o(ctl_upd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  logic drv_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (drv !== drv_prev && scl) r11_viol++;
      drv_prev = drv;
      if (div_upd) begin
        if (exp_q.size() == 0) chk("R7 unexpected divider strobe", {15'd0, 1'b0, div_w}, 32'h1ffff);
        else chk("R5 R6 divider word", {15'd0, 1'b0, div_w}, {15'd0, exp_q.pop_front()});
      end
      if (ctl_upd) begin
        if (exp_q.size() == 0) chk("R7 unexpected control strobe", {15'd0, 1'b1, ctl_w}, 32'h1ffff);
        else chk("R5 R6 control word", {15'd0, 1'b1, ctl_w}, {15'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic i2c_start();
    sda_m = 1'b1; #Q;
    scl = 1'b1;   #Q;
    sda_m = 1'b0; #Q;
    scl = 1'b0;   #Q;
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; #Q;
    scl = 1'b1;   #Q;
    sda_m = 1'b1; #Q;
  endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; #Q;
    scl = 1'b1; #Q;
    r = sda_bus; #Q;
    scl = 1'b0; #Q;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, r);
      v[i] = r;
    end
    bit_io(~mack, r);
  endtask

  // driver: sends the body of a write frame and queues the words the stop must load
  task automatic write_body(input logic [6:0] a, input int n,
                            input logic [7:0] b0, b1, b2, b3, input string req);
    logic ack;
    logic match;
    logic [7:0] bs[4];
    logic [15:0] nd, nc;
    logic hd, hc;
    bs = '{b0, b1, b2, b3};
    match = (a == {BASE[6:2], addr_sel});
    put_byte({a, 1'b0}, ack);
    chk({req, " R2 R3 address ack"}, {31'd0, ack}, {31'd0, match});
    for (int i = 0; i < n; i++) begin
      put_byte(bs[i], ack);
      chk({req, " R4 R3 data ack"}, {31'd0, ack}, {31'd0, match});
    end
    hd = 1'b0; hc = 1'b0; nd = '0; nc = '0;
    if (match) begin
      for (int i = 0; i + 1 < n; i += 2) begin
        if (bs[i][7]) begin hc = 1'b1; nc = {bs[i], bs[i+1]}; end
        else begin hd = 1'b1; nd = {bs[i], bs[i+1]}; end
      end
    end
    if (hd) begin exp_q.push_back({1'b0, nd}); m_div = nd; end
    if (hc) begin exp_q.push_back({1'b1, nc}); m_ctl = nc; end
  endtask

  task automatic settle_and_compare(input string req);
    #(4*Q);
    chk({req, " queue drained"}, exp_q.size(), 0);
    chk({req, " divider word"}, {16'd0, div_w}, {16'd0, m_div});
    chk({req, " control word"}, {16'd0, ctl_w}, {16'd0, m_ctl});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8ns);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1 drive in reset", {31'd0, drv}, 0);
    chk("R1 divider in reset", {16'd0, div_w}, 0);
    chk("R1 control in reset", {16'd0, ctl_w}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 strobes after reset", {30'd0, div_upd, ctl_upd}, 0);
    chk("R1 drive after reset", {31'd0, drv}, 0);

    i2c_start(); write_body(7'h60, 4, 8'h12, 8'h34, 8'h86, 8'h5A, "R6 div-ctl");
    i2c_stop(); settle_and_compare("R6 div-ctl");

    i2c_start(); write_body(7'h60, 4, 8'hC1, 8'h22, 8'h3F, 8'hEE, "R6 ctl-div");
    i2c_stop(); settle_and_compare("R6 ctl-div");

    i2c_start(); write_body(7'h60, 2, 8'h05, 8'h77, 8'h00, 8'h00, "R7 divider only");
    i2c_stop(); settle_and_compare("R7 divider only");

    addr_sel = 2'd2;
    i2c_start(); write_body(7'h62, 2, 8'h9A, 8'h01, 8'h00, 8'h00, "R7 control only");
    i2c_stop(); settle_and_compare("R7 control only");

    i2c_start(); write_body(7'h61, 2, 8'h11, 8'h22, 8'h00, 8'h00, "R3 wrong address");
    i2c_stop(); settle_and_compare("R3 wrong address");

    i2c_start(); write_body(7'h62, 3, 8'h0A, 8'h0B, 8'h80, 8'h00, "R8 odd byte");
    i2c_stop(); settle_and_compare("R8 odd byte");

    i2c_start(); write_body(7'h62, 1, 8'h8F, 8'h00, 8'h00, 8'h00, "R8 lone byte");
    i2c_stop(); settle_and_compare("R8 lone byte");

    // R9: first section is abandoned; expectations for it are not queued
    i2c_start();
    put_byte({7'h62, 1'b0}, ack);
    put_byte(8'h44, ack);
    put_byte(8'h55, ack);
    chk("R9 ack before repeated start", {31'd0, ack}, 1);
    i2c_start(); write_body(7'h62, 2, 8'hF0, 8'h0F, 8'h00, 8'h00, "R9 repeated start");
    i2c_stop(); settle_and_compare("R9 repeated start");

    status = 8'hA5;
    i2c_start();
    put_byte({7'h62, 1'b1}, ack);
    chk("R2 read address ack", {31'd0, ack}, 1);
    get_byte(1'b1, v);
    chk("R10 first status byte", {24'd0, v}, 32'hA5);
    get_byte(1'b0, v);
    chk("R10 repeated status byte", {24'd0, v}, 32'hA5);
    chk("R10 released after nack", {31'd0, drv}, 0);
    get_byte(1'b0, v);
    chk("R10 silent after nack", {24'd0, v}, 32'hFF);
    i2c_stop(); settle_and_compare("R10 read leaves words");

    status = 8'h3C;
    i2c_start();
    put_byte({7'h60, 1'b1}, ack);
    chk("R3 read wrong address", {31'd0, ack}, 0);
    get_byte(1'b0, v);
    chk("R3 no data when unaddressed", {24'd0, v}, 32'hFF);
    i2c_stop();
    addr_sel = 2'd0;
    i2c_start();
    put_byte({7'h60, 1'b1}, ack);
    get_byte(1'b0, v);
    chk("R10 status 3C", {24'd0, v}, 32'h3C);
    i2c_stop();
    #(4*Q);

    chk("R11 drive changed only while SCL low", r11_viol, 0);
    finish_run();
  end
endmodule